// File: doc/BRIEF.md
# Keypad Select and Interrupt Controller

This block combines the input-select register of an eight-button matrix with a five-source interrupt controller. Software writes two select bits to choose which half of the button matrix appears in the low nibble of the select register. A button reads as 0 when pressed. The block watches that nibble and raises the keypad interrupt flag whenever any nibble line falls from 1 to 0. The nibble can change because software changed the selection or because the buttons changed.

The interrupt side holds a flag register and an enable register. The timer, serial and two video sources deliver single-cycle event pulses, and each pulse sets its own flag bit. A registered request line to the CPU is high whenever a pending flag is also enabled. The request is recomputed on every update, including writes to the flag and enable registers, so a write can also drop it.

Register access uses plain control pins: one write port and one combinational read port, with no handshake. Interrupt acknowledge and vectoring belong to the CPU and are not part of this block.

Top module: `keypad_irq_ctrl`

## Requirements
- R1: After reset, the select register reads 0xCF when all buttons are released, the flag register reads 0xE0, the enable register reads 0x00 and `irq_req` is low.
- R2: Register address 0 is the select register, 1 the flag register and 2 the enable register. Address 3 reads 0xFF, and a write to it changes no register. `rd_data` follows `rd_addr` combinationally.
- R3: A write to the select register stores only data bits 5:4. Reads of the select register return bits 7:6 as 1, bits 5:4 as the stored selection and bits 3:0 as the key nibble.
- R4: The key nibble depends on the select bits 5:4. With 10 it shows `btn_n[3:0]`. With 01 it shows `btn_n[7:4]`. With 00 it shows the bitwise AND of both halves. With 11 it shows 0xF. The nibble updates in the cycle after a select write or a button change.
- R5: If a select write makes any nibble bit fall from 1 to 0, flag bit 4 is set in the same cycle as the nibble update.
- R6: If a button change makes any nibble bit fall from 1 to 0, flag bit 4 is set in the same way. A change to a button in the half that is not selected has no effect.
- R7: Reads of the flag register return bits 7:5 as 1. A write stores data bits 4:0.
- R8: A one-cycle pulse on `vblank_evt`, `lcd_stat_evt`, `timer_evt` or `serial_evt` sets flag bit 0, 1, 2 or 3 respectively. A set in the same cycle as a flag write wins over the written 0.
- R9: The enable register stores all eight written bits and reads them back unchanged.
- R10: From the edge that updates the registers, `irq_req` is high exactly when (flag bits 4:0 AND enable bits 4:0) is nonzero. A write that leaves this AND at zero drops the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 8 | Read data, combinational |
| btn_n | input | 8 | Button matrix, active low |
| vblank_evt | input | 1 | Vertical-blank event pulse |
| lcd_stat_evt | input | 1 | Display-status event pulse |
| timer_evt | input | 1 | Timer event pulse |
| serial_evt | input | 1 | Serial event pulse |
| irq_req | output | 1 | Interrupt request to the CPU |

## Verification
The assertions check on every cycle that the forced-one bits of the select and flag reads hold, that address 3 reads 0xFF, that the request level matches the pending and enabled flags, that a falling nibble leaves flag bit 4 set, that a timer pulse sets its flag and that an enable write is stored. Only the bench scenarios can show the exact nibble mapping for every selection and button pattern, the exact stored flag value after a write, the win of a source set over a same-cycle clearing write, and that a write to the unused address or a press in the unselected half leaves state untouched.

// File: rtl/kp_irq_pkg.sv
package kp_irq_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 2;
  localparam int NUM_SRC = 5;

  typedef enum logic [ADDR_W-1:0] {
    REG_SEL  = 2'd0,
    REG_FLAG = 2'd1,
    REG_EN   = 2'd2,
    REG_NONE = 2'd3
  } reg_addr_e;

  localparam int SRC_VBL  = 0;
  localparam int SRC_STAT = 1;
  localparam int SRC_TMR  = 2;
  localparam int SRC_SER  = 3;
  localparam int SRC_KEY  = 4;
endpackage

// File: rtl/kp_matrix_sel.sv
module kp_matrix_sel #(
  parameter int BTN_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_we,
  input  logic [1:0]         sel_wdata,
  input  logic [BTN_W-1:0]   btn_n,
  output logic [1:0]         sel_q,
  output logic [BTN_W/2-1:0] nib_q,
  output logic               key_fall
);
  localparam int HALF = BTN_W / 2;

  logic [1:0]      sel_d;
  logic [HALF-1:0] nib_d;
  logic [HALF-1:0] lo_half;
  logic [HALF-1:0] hi_half;

  assign lo_half = btn_n[HALF-1:0];
  assign hi_half = btn_n[BTN_W-1:HALF];

  always_comb begin
    sel_d = sel_we ? sel_wdata : sel_q;
    unique case (sel_d)
      2'b10:   nib_d = lo_half;
      2'b01:   nib_d = hi_half;
      2'b00:   nib_d = lo_half & hi_half;
      default: nib_d = '1;
    endcase
  end

  // any line that was high and is about to go low
  assign key_fall = |(nib_q & ~nib_d);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= 2'b00;
      nib_q <= '1;
    end else begin
      sel_q <= sel_d;
      nib_q <= nib_d;
    end
  end
endmodule

// File: rtl/kp_irq_flags.sv
module kp_irq_flags #(
  parameter int NSRC = 5,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flag_we,
  input  logic            en_we,
  input  logic [DW-1:0]   wdata,
  input  logic [NSRC-1:0] src_set,
  output logic [NSRC-1:0] flag_q,
  output logic [DW-1:0]   en_q,
  output logic            irq_q
);
  logic [NSRC-1:0] flag_d;
  logic [DW-1:0]   en_d;

  // per-source next state: a set from the source dominates a write
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign flag_d[i] = src_set[i] | (flag_we ? wdata[i] : flag_q[i]);
  end

  assign en_d = en_we ? wdata : en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      en_q   <= en_d;
      irq_q  <= |(flag_d & en_d[NSRC-1:0]);
    end
  end
endmodule

// File: rtl/keypad_irq_ctrl.sv
module keypad_irq_ctrl
  import kp_irq_pkg::*;
#(
  parameter int BTN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [BTN_W-1:0]  btn_n,
  input  logic              vblank_evt,
  input  logic              lcd_stat_evt,
  input  logic              timer_evt,
  input  logic              serial_evt,
  output logic              irq_req
);
  localparam int HALF    = BTN_W / 2;
  localparam int SEL_PAD = DATA_W - 2 - HALF;
  localparam int FLG_PAD = DATA_W - NUM_SRC;

  logic [1:0]         sel_bits;
  logic [HALF-1:0]    key_nib;
  logic               key_fall;
  logic [NUM_SRC-1:0] src_set;
  logic [NUM_SRC-1:0] flag_bits;
  logic [DATA_W-1:0]  en_bits;
  logic               sel_we, flag_we, en_we;

  assign sel_we  = wr_en && (wr_addr == REG_SEL);
  assign flag_we = wr_en && (wr_addr == REG_FLAG);
  assign en_we   = wr_en && (wr_addr == REG_EN);

  always_comb begin
    src_set           = '0;
    src_set[SRC_VBL]  = vblank_evt;
    src_set[SRC_STAT] = lcd_stat_evt;
    src_set[SRC_TMR]  = timer_evt;
    src_set[SRC_SER]  = serial_evt;
    src_set[SRC_KEY]  = key_fall;
  end

  kp_matrix_sel #(.BTN_W(BTN_W)) u_matrix (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_we   (sel_we),
    .sel_wdata(wr_data[HALF+1:HALF]),
    .btn_n    (btn_n),
    .sel_q    (sel_bits),
    .nib_q    (key_nib),
    .key_fall (key_fall)
  );

  kp_irq_flags #(.NSRC(NUM_SRC), .DW(DATA_W)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .flag_we(flag_we),
    .en_we  (en_we),
    .wdata  (wr_data),
    .src_set(src_set),
    .flag_q (flag_bits),
    .en_q   (en_bits),
    .irq_q  (irq_req)
  );

  always_comb begin
    unique case (rd_addr)
      REG_SEL:  rd_data = {{SEL_PAD{1'b1}}, sel_bits, key_nib};
      REG_FLAG: rd_data = {{FLG_PAD{1'b1}}, flag_bits};
      REG_EN:   rd_data = en_bits;
      default:  rd_data = '1;
    endcase
  end
endmodule

// File: rtl/kp_irq_checker.sv
module kp_irq_checker #(
  parameter int DW   = 8,
  parameter int NSRC = 5,
  parameter int HALF = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [1:0]      wr_addr,
  input logic [DW-1:0]   wr_data,
  input logic [1:0]      rd_addr,
  input logic [DW-1:0]   rd_data,
  input logic            timer_evt,
  input logic [HALF-1:0] key_nib,
  input logic [NSRC-1:0] flag_bits,
  input logic [DW-1:0]   en_bits,
  input logic            irq_req
);
  assert_sel_top_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 2'd0) |-> (rd_data[DW-1:DW-2] == 2'b11));

  assert_flag_top_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 2'd1) |-> (&rd_data[DW-1:NSRC]));

  assert_unmapped_reads_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 2'd3) |-> (&rd_data));

  assert_timer_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timer_evt |=> flag_bits[2]);

  // covers both R5 and R6: any falling nibble line leaves the keypad flag set
  assert_key_fall_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(key_nib) & ~key_nib)) |-> flag_bits[NSRC-1]);

  assert_irq_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req == (|(flag_bits & en_bits[NSRC-1:0])));

  assert_enable_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd2) |=> (en_bits == $past(wr_data)));
endmodule

bind keypad_irq_ctrl kp_irq_checker #(.DW(DATA_W), .NSRC(NUM_SRC), .HALF(HALF)) u_kp_irq_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .rd_addr  (rd_addr),
  .rd_data  (rd_data),
  .timer_evt(timer_evt),
  .key_nib  (key_nib),
  .flag_bits(flag_bits),
  .en_bits  (en_bits),
  .irq_req  (irq_req)
);

// File: tb/test_keypad_irq_ctrl.sv
module test_keypad_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] rd_data;
  logic [7:0] btn_n = 8'hFF;
  logic       vblank_evt = 1'b0, lcd_stat_evt = 1'b0, timer_evt = 1'b0, serial_evt = 1'b0;
  logic       irq_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  keypad_irq_ctrl i_keypad_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .btn_n(btn_n),
    .vblank_evt(vblank_evt), .lcd_stat_evt(lcd_stat_evt), .timer_evt(timer_evt),
    .serial_evt(serial_evt), .irq_req(irq_req)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  // called at a negedge; returns at the next negedge with the write applied
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [3:0] exp_nib(input logic [1:0] s, input logic [7:0] b);
    case (s)
      2'b10:   return b[3:0];
      2'b01:   return b[7:4];
      2'b00:   return b[3:0] & b[7:4];
      default: return 4'hF;
    endcase
  endfunction

  initial begin
    logic [7:0] v, v_sel, v_flg, v_en;
    logic [3:0] n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk(v, 8'hCF, "R1 select reset");
    rd(2'd1, v); chk(v, 8'hE0, "R1 flag reset");
    rd(2'd2, v); chk(v, 8'h00, "R1 enable reset");
    chk({7'd0, irq_req}, 8'h00, "R1 irq reset");

    // R3 R4 R5: sweep every selection against every button pattern
    for (int s = 0; s < 4; s++) begin
      for (int b = 0; b < 256; b++) begin
        btn_n = b[7:0];
        wr(2'd0, 8'hFF);          // park on selection 11, nibble F
        wr(2'd1, 8'h00);          // clear pending flags
        wr(2'd0, {2'b00, s[1:0], 4'h5});
        n = exp_nib(s[1:0], b[7:0]);
        rd(2'd0, v); chk(v, {2'b11, s[1:0], n}, "R3 R4 select readback");
        rd(2'd1, v); chk(v, {3'b111, (n != 4'hF), 4'h0}, "R5 keypad flag on select");
      end
    end

    // R6 button change under a fixed selection
    btn_n = 8'hFF;
    wr(2'd0, 8'h20);
    wr(2'd1, 8'h00);
    btn_n = 8'hFB;
    @(negedge clk);
    rd(2'd0, v); chk(v, 8'hEB, "R6 nibble follows buttons");
    rd(2'd1, v); chk(v, 8'hF0, "R6 keypad flag on press");
    btn_n = 8'hFF;
    @(negedge clk);
    wr(2'd1, 8'h00);
    btn_n = 8'hBF;                // unselected upper half
    @(negedge clk);
    @(negedge clk);
    rd(2'd0, v); chk(v, 8'hEF, "R6 unselected half ignored nibble");
    rd(2'd1, v); chk(v, 8'hE0, "R6 unselected half ignored flag");
    btn_n = 8'hFF;
    @(negedge clk);

    // R7 R9 R10: sweep enable and flag combinations
    for (int e = 0; e < 32; e++) begin
      for (int f = 0; f < 32; f++) begin
        wr(2'd2, {e[2:0], e[4:0]});
        rd(2'd2, v); chk(v, {e[2:0], e[4:0]}, "R9 enable readback");
        wr(2'd1, {3'b000, f[4:0]});
        rd(2'd1, v); chk(v, {3'b111, f[4:0]}, "R7 flag readback");
        chk({7'd0, irq_req}, {7'd0, |(e[4:0] & f[4:0])}, "R10 irq level");
      end
    end

    // R8 peripheral sources
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h00);
    vblank_evt = 1'b1;   @(negedge clk); vblank_evt = 1'b0;
    rd(2'd1, v); chk(v, 8'hE1, "R8 vblank sets bit 0");
    lcd_stat_evt = 1'b1; @(negedge clk); lcd_stat_evt = 1'b0;
    rd(2'd1, v); chk(v, 8'hE3, "R8 status sets bit 1");
    timer_evt = 1'b1;    @(negedge clk); timer_evt = 1'b0;
    rd(2'd1, v); chk(v, 8'hE7, "R8 timer sets bit 2");
    serial_evt = 1'b1;   @(negedge clk); serial_evt = 1'b0;
    rd(2'd1, v); chk(v, 8'hEF, "R8 serial sets bit 3");
    chk({7'd0, irq_req}, 8'h00, "R10 no irq when disabled");
    wr(2'd2, 8'h08);
    chk({7'd0, irq_req}, 8'h01, "R10 irq after enable write");
    serial_evt = 1'b1;
    wr(2'd1, 8'h00);
    serial_evt = 1'b0;
    rd(2'd1, v); chk(v, 8'hE8, "R8 set wins over write");
    chk({7'd0, irq_req}, 8'h01, "R10 irq held by winning set");
    wr(2'd1, 8'h00);
    chk({7'd0, irq_req}, 8'h00, "R10 irq dropped by write");

    // R2 unused address
    wr(2'd2, 8'h5A);
    wr(2'd1, 8'h06);
    wr(2'd0, 8'h10);
    rd(2'd0, v_sel); rd(2'd1, v_flg); rd(2'd2, v_en);
    wr(2'd3, 8'h00);
    rd(2'd0, v); chk(v, v_sel, "R2 unused write keeps select");
    rd(2'd1, v); chk(v, v_flg, "R2 unused write keeps flag");
    rd(2'd2, v); chk(v, v_en, "R2 unused write keeps enable");
    rd(2'd3, v); chk(v, 8'hFF, "R2 unused reads ones");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule